// File: doc/BRIEF.md
# Cluster Last-Fiber Jump Mask

This block works out which fibers of a wave follow a special jump: the jump is taken by the fibers of the lowest-numbered cluster that holds any active fiber, apart from that cluster's last active fiber. Fibers are grouped into fixed clusters of eight: fibers 8k to 8k+7 form cluster k. All fibers outside the selected cluster stay on the fall-through path.

The instruction carries a 3-bit width field. Its nominal cluster size is 2 shifted left by the field value, but that value is only shown when the instruction is printed. The logic ignores it and always uses clusters of eight.

On every strobe the block captures the active-fiber mask and registers three results. The taken mask is used for the branch target. The not-taken mask is used for the next sequential instruction. A flag reports that no fiber was active. The target address and the program-counter update belong to the surrounding sequencer. The fiber count is a parameter and must be a multiple of eight.

Top module: `cluster_jump_mask`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The three results change only on a clock edge where `in_valid` is high, and hold their values otherwise.
- R2: When the captured active mask is all zero, `none_active` is 1 and both `taken_mask` and `fallthru_mask` are zero. Otherwise `none_active` is 0.
- R3: Set bits of `taken_mask` lie only in the lowest-numbered cluster whose eight fibers (8k..8k+7) contain at least one active fiber.
- R4: Within that cluster, the highest-indexed active fiber is not taken, and every other active fiber of the cluster is taken.
- R5: An inactive fiber appears in neither mask, and `fallthru_mask` equals the active mask with the taken fibers removed.
- R6: The 3-bit `width_sel` field has no effect: all eight values give the same outputs for the same active mask.
- R7: After reset, `out_valid`, both masks and `none_active` are zero.
- R8: If the selected cluster holds only one active fiber, `taken_mask` is zero and that fiber is in `fallthru_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture the active mask this cycle |
| active_mask | input | NUM_FIBERS | Active-fiber mask, bit i is fiber i |
| width_sel | input | 3 | Encoded cluster-size field, ignored by the logic |
| out_valid | output | 1 | Results updated from the previous strobe |
| taken_mask | output | NUM_FIBERS | Fibers that take the jump |
| fallthru_mask | output | NUM_FIBERS | Active fibers that do not take the jump |
| none_active | output | 1 | Captured active mask was all zero |

## Verification
Every result comes from one register stage, so the outputs for a strobe are due one edge later. A 16-fiber instance receives a new strobe at each falling edge. At the next falling edge, the bench compares the outputs with the value it computed for the previous strobe, so each sample falls exactly one edge after its stimulus. For the hold check, the bench lowers `in_valid`, changes the active mask, and looks one edge later for unchanged results with `out_valid` low. The width sweep repeats the same masks with all eight `width_sel` values and expects identical outputs.

// File: rtl/cluster_jump_mask.sv
module cluster_jump_mask #(
  parameter int NUM_FIBERS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [NUM_FIBERS-1:0] active_mask,
  input  logic [2:0]            width_sel,
  output logic                  out_valid,
  output logic [NUM_FIBERS-1:0] taken_mask,
  output logic [NUM_FIBERS-1:0] fallthru_mask,
  output logic                  none_active
);
  localparam int CL = 8;
  localparam int NCL = NUM_FIBERS / CL;

  initial begin
    if (NUM_FIBERS % CL != 0 || NUM_FIBERS == 0)
      $error("NUM_FIBERS must be a nonzero multiple of 8");
  end

  function automatic logic [CL-1:0] top_one(input logic [CL-1:0] b);
    logic [CL-1:0] r;
    r = '0;
    for (int i = 0; i < CL; i++)
      if (b[i]) r = CL'(1) << i;
    return r;
  endfunction

  logic [NCL-1:0]        cl_any;
  logic [NCL-1:0]        first_cl;
  logic [NUM_FIBERS-1:0] take_d;

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    logic [CL-1:0] slice;
    assign slice = active_mask[c*CL +: CL];
    assign cl_any[c] = |slice;
    assign take_d[c*CL +: CL] = first_cl[c] ? (slice & ~top_one(slice)) : '0;
  end

  assign first_cl = cl_any & (~cl_any + NCL'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      taken_mask    <= '0;
      fallthru_mask <= '0;
      none_active   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken_mask    <= take_d;
        fallthru_mask <= active_mask & ~take_d;
        none_active   <= ~|cl_any;
      end
    end
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R5
  taken_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (taken_mask & ~$past(active_mask)) == '0);

  // R5
  disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_mask & fallthru_mask) == '0);

  // R2
  none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none_active |-> (taken_mask == '0 && fallthru_mask == '0));

  // R4
  last_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !none_active) |-> fallthru_mask != '0);

  // R6
  width_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !$isunknown(width_sel));
endmodule

// File: tb/sim_cluster_jump_mask.sv
module sim_cluster_jump_mask;
  localparam int NF = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [NF-1:0] active_mask = '0;
  logic [2:0]    width_sel = '0;
  logic          out_valid;
  logic [NF-1:0] taken_mask;
  logic [NF-1:0] fallthru_mask;
  logic          none_active;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cluster_jump_mask #(.NUM_FIBERS(NF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .active_mask(active_mask),
    .width_sel(width_sel), .out_valid(out_valid), .taken_mask(taken_mask),
    .fallthru_mask(fallthru_mask), .none_active(none_active)
  );

  function automatic logic [NF-1:0] model_take(input logic [NF-1:0] a);
    logic [NF-1:0] t;
    t = '0;
    for (int c = 0; c < NF / 8; c++) begin
      logic [7:0] b;
      b = a[c*8 +: 8];
      if (b != 0) begin
        int hi;
        hi = 0;
        for (int j = 0; j < 8; j++) if (b[j]) hi = j;
        b[hi] = 1'b0;
        t[c*8 +: 8] = b;
        break;
      end
    end
    return t;
  endfunction

  task automatic check(input string req, input logic [NF-1:0] a,
                       input logic ov_exp);
    logic [NF-1:0] et;
    logic [NF-1:0] ef;
    logic          en;
    et = model_take(a);
    ef = a & ~et;
    en = (a == '0);
    total++;
    if (out_valid !== ov_exp || taken_mask !== et || fallthru_mask !== ef ||
        none_active !== en) begin
      bad++;
      $display("FAIL %s a=%h: got v=%b t=%h f=%h n=%b exp v=%b t=%h f=%h n=%b",
               req, a, out_valid, taken_mask, fallthru_mask, none_active,
               ov_exp, et, ef, en);
    end
  endtask

  initial begin
    logic [NF-1:0] prev;
    logic [NF-1:0] ref_t;
    string         tag;
    repeat (3) @(negedge clk);
    total++;
    // R7
    if (out_valid !== 1'b0 || taken_mask !== '0 || fallthru_mask !== '0 ||
        none_active !== 1'b0) begin
      bad++;
      $display("FAIL R7 reset: v=%b t=%h f=%h n=%b exp all zero",
               out_valid, taken_mask, fallthru_mask, none_active);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R8: exhaustive sweep of all 16-fiber masks
    for (int p = 0; p < (1 << NF); p++) begin
      in_valid = 1'b1;
      active_mask = NF'(p);
      width_sel = 3'(p);
      @(negedge clk);
      prev = NF'(p);
      if (prev == '0) tag = "R2";
      else if ($countones(prev[7:0]) == 1 ||
               (prev[7:0] == 0 && $countones(prev[15:8]) == 1)) tag = "R8";
      else if (prev[7:0] != 0 && prev[15:8] != 0) tag = "R3";
      else tag = "R4/R5";
      check(tag, prev, 1'b1);
    end

    // R6: every width value on a subset of masks
    for (int p = 0; p < 256; p++) begin
      for (int w = 0; w < 8; w++) begin
        in_valid = 1'b1;
        active_mask = NF'(p * 97 + 3);
        width_sel = 3'(w);
        @(negedge clk);
        check("R6", NF'(p * 97 + 3), 1'b1);
      end
    end

    // R1: strobe low, results hold, out_valid drops
    in_valid = 1'b1;
    active_mask = 16'h0C30;
    @(negedge clk);
    check("R1", 16'h0C30, 1'b1);
    ref_t = taken_mask;
    in_valid = 1'b0;
    active_mask = 16'hFFFF;
    @(negedge clk);
    check("R1", 16'h0C30, 1'b0);
    @(negedge clk);
    check("R1", 16'h0C30, 1'b0);
    total++;
    if (ref_t !== 16'h0010) begin
      bad++;
      $display("FAIL R4 t=%h exp 0010", ref_t);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule